// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Reload Timer

This block holds two 16-bit down-counters behind a small byte-wide register port. Each counter decrements on a count tick chosen by a 3-bit source code. The tick comes from a shared free-running prescaler on the system clock, or from an alternate source. For the first counter the alternate source is a synchronised external count input. For the second counter it is the first counter's underflow pulse, so the two can be cascaded into one longer timer. When a counter at zero receives a tick it underflows. It then reloads the value software last wrote and, if its interrupt is enabled, sets its interrupt flag. The second counter has an auto-reload enable. With that bit clear it parks at zero after one underflow.

Every counter runs on the system clock. The prescaler only produces single-cycle enable pulses. Software reads the 16-bit count one byte at a time. Reading the high byte captures the low byte at the same instant, so a later low-byte read gives a consistent pair. Loads also go a byte at a time: the low byte is written first and only staged, and the high-byte write commits the full 16-bit value.

Top module: `cascade_reload_timer`

## Requirements
- R1: After reset both counts, reload values, the control register (address 4) and the interrupt register (address 5) read as zero, and both irq outputs are low.
- R2: Control register address 4 holds the first counter's source in bits [2:0], the second counter's source in bits [5:3] and the second counter's auto-reload enable in bit 7. Source codes 0 to 6 give one tick every 1, 4, 8, 16, 32, 64 and 128 clock cycles. Code 0 is every cycle, and code c≥1 is one tick per 2^(c+1) cycles.
- R3: Each tick decrements a nonzero count by one. A tick at zero is an underflow and reloads the stored value. With reload value N and source divisor D, successive underflows are (N+1)·D cycles apart.
- R4: Source code 7 makes the first counter count rising edges of `ext_cnt`, after a two-flop synchroniser, and makes the second counter count underflows of the first.
- R5: Address 1 (first counter) and address 3 (second counter) read the live high count byte and, in the same access, capture the low byte. Addresses 0 and 2 return that captured low byte until the next high-byte read, even if the counter moves in between.
- R6: A write to address 0 or 2 only stages the low byte and leaves counting untouched. The following write to address 1 or 3 loads {high, staged low} into both the count and the reload value.
- R7: Writing zero to the low and then the high byte leaves the count at 0000h.
- R8: A write to address 5 is a command. Bit 0 enables and bit 1 disables-and-clears the first counter's interrupt. Bits 2 and 3 do the same for the second counter. A read of address 5 returns the flags in bits 0 and 1 and the enables in bits 4 and 5. A flag sets on underflow only while its enable is set, and `irq[i]` equals flag i.
- R9: With auto-reload clear, the second counter stops at 0000h after one underflow, sets its flag at most once, and ignores further ticks until it is loaded again. With the bit set, it reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (high-byte reads capture the low byte) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ext_cnt | input | 1 | Asynchronous external count input |
| irq | output | 2 | Interrupt flags, bit 0 first counter, bit 1 second |

## Verification
The bench measures the distance between successive underflows for several source codes. A prescaler tap off by one would shift those periods by a factor of two, and a reload off by one would add or drop one divisor's worth of cycles. With the count frozen, it moves the counter between a high-byte read and a low-byte read. A design that returned the live low byte would then show the decremented value. It issues a lone low-byte write and checks that the count is unchanged, which a design that loaded on every byte write would fail. It also drives the cascade with auto-reload off. A counter that kept reloading or re-flagging there would raise a second flag or read nonzero.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam logic [2:0] ADR_T0_LO = 3'd0;
    localparam logic [2:0] ADR_T0_HI = 3'd1;
    localparam logic [2:0] ADR_T1_LO = 3'd2;
    localparam logic [2:0] ADR_T1_HI = 3'd3;
    localparam logic [2:0] ADR_CTRL  = 3'd4;
    localparam logic [2:0] ADR_IRQ   = 3'd5;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int PSC_W = 7,
    parameter int NSRC  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NSRC-1:0] tick_o
);
    logic [PSC_W-1:0] psc_d, psc_q;

    always_comb begin
        psc_d = psc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    assign tick_o[0] = 1'b1;
    for (genvar i = 1; i < NSRC; i++) begin : g_tap
        if (i < PSC_W) begin : g_live
            assign tick_o[i] = &psc_q[i:0];
            // divided ticks are single-cycle pulses
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o[i] |=> !tick_o[i]);
        end else begin : g_none
            assign tick_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/reload_chan.sv
module reload_chan #(
    parameter int BUS_W  = 8,
    parameter bit HAS_AR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             rd_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             ar_en_i,
    input  logic             int_set_i,
    input  logic             int_clr_i,
    output logic [BUS_W-1:0] cnt_hi_o,
    output logic [BUS_W-1:0] snap_lo_o,
    output logic             uf_o,
    output logic             flag_o,
    output logic             en_o
);
    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [BUS_W-1:0] stage;
        logic [BUS_W-1:0] snap;
        logic             stop;
        logic             flag;
        logic             en;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic reload_on, uf;

    assign reload_on = !HAS_AR || ar_en_i;
    assign uf        = tick_i && (st_q.cnt == '0) && !st_q.stop && !wr_hi_i;

    always_comb begin
        st_d = st_q;
        if (wr_lo_i) st_d.stage = wdata_i;
        if (rd_hi_i) st_d.snap  = st_q.cnt[BUS_W-1:0];
        if (wr_hi_i) begin
            st_d.cnt  = {wdata_i, st_q.stage};
            st_d.rld  = {wdata_i, st_q.stage};
            st_d.stop = 1'b0;
        end else if (tick_i && !st_q.stop) begin
            if (st_q.cnt != '0)  st_d.cnt  = st_q.cnt - 1'b1;
            else if (reload_on)  st_d.cnt  = st_q.rld;
            else                 st_d.stop = 1'b1;
        end
        if (int_set_i)       st_d.en = 1'b1;
        else if (int_clr_i)  st_d.en = 1'b0;
        if (uf && st_q.en)   st_d.flag = 1'b1;
        else if (int_clr_i)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_hi_o  = st_q.cnt[CNT_W-1:BUS_W];
    assign snap_lo_o = st_q.snap;
    assign uf_o      = uf;
    assign flag_o    = st_q.flag;
    assign en_o      = st_q.en;

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_hi_i && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && reload_on) |=> st_q.cnt == $past(st_q.rld));
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_hi_i) |=> $stable(st_q.cnt));
    assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> st_q.snap == $past(st_q.cnt[BUS_W-1:0]));
    assert_flag_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(st_q.en));
    assert_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !wr_hi_i) |=> (st_q.cnt == '0 && st_q.stop));
endmodule

// File: rtl/cascade_reload_timer.sv
module cascade_reload_timer
    import timer_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 3,
    parameter int PSC_W  = 7,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_cnt,
    output logic [1:0]        irq
);
    localparam int NSRC = 1 << SEL_W;
    localparam logic [SEL_W-1:0] SRC_ALT = SEL_W'(NSRC - 1);

    typedef struct packed {
        logic             ar;
        logic [SEL_W-1:0] src1;
        logic [SEL_W-1:0] src0;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [NSRC-1:0]  div_tick;
    logic             ext_rise;
    logic [1:0]       tick, uf, flag, en, wr_lo, wr_hi, rd_hi, i_set, i_clr;
    logic [BUS_W-1:0] cnt_hi [2];
    logic [BUS_W-1:0] snap_lo [2];
    logic             wr_ctrl, wr_cmd;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(ADR_IRQ));

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.src0 = bus_wdata[SEL_W-1:0];
            ctrl_d.src1 = bus_wdata[2*SEL_W-1:SEL_W];
            ctrl_d.ar   = bus_wdata[BUS_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tick_divider #(.PSC_W(PSC_W), .NSRC(NSRC)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_o(div_tick));

    edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_cnt), .rise_o(ext_rise));

    assign tick[0] = (ctrl_q.src0 == SRC_ALT) ? ext_rise : div_tick[ctrl_q.src0];
    assign tick[1] = (ctrl_q.src1 == SRC_ALT) ? uf[0]    : div_tick[ctrl_q.src1];

    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign wr_lo[c] = bus_wr && (bus_addr == ADDR_W'(2 * c));
        assign wr_hi[c] = bus_wr && (bus_addr == ADDR_W'(2 * c + 1));
        assign rd_hi[c] = bus_rd && (bus_addr == ADDR_W'(2 * c + 1));
        assign i_set[c] = wr_cmd && bus_wdata[2 * c];
        assign i_clr[c] = wr_cmd && bus_wdata[2 * c + 1];

        reload_chan #(.BUS_W(BUS_W), .HAS_AR(c == 1)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick_i(tick[c]),
            .wr_lo_i(wr_lo[c]), .wr_hi_i(wr_hi[c]), .rd_hi_i(rd_hi[c]),
            .wdata_i(bus_wdata), .ar_en_i(ctrl_q.ar),
            .int_set_i(i_set[c]), .int_clr_i(i_clr[c]),
            .cnt_hi_o(cnt_hi[c]), .snap_lo_o(snap_lo[c]), .uf_o(uf[c]),
            .flag_o(flag[c]), .en_o(en[c]));
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_T0_LO): bus_rdata = snap_lo[0];
            ADDR_W'(ADR_T0_HI): bus_rdata = cnt_hi[0];
            ADDR_W'(ADR_T1_LO): bus_rdata = snap_lo[1];
            ADDR_W'(ADR_T1_HI): bus_rdata = cnt_hi[1];
            ADDR_W'(ADR_CTRL):  bus_rdata = {ctrl_q.ar, 1'b0, ctrl_q.src1, ctrl_q.src0};
            ADDR_W'(ADR_IRQ):   bus_rdata = BUS_W'({en, 2'b00, flag});
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = flag;

    assert_cascade_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.src1 == SRC_ALT && !uf[0]) |-> !tick[1]);
endmodule

// File: tb/tb_cascade_reload_timer.sv
module tb_cascade_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_cnt = 1'b0;
    logic [1:0] irq;

    int n_checks = 0, n_fail = 0;
    longint cyc = 0;
    bit done = 1'b0;

    cascade_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_cnt(ext_cnt), .irq(irq));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load(input int ch, input logic [15:0] v);
        wr(3'(2 * ch), v[7:0]);
        wr(3'(2 * ch + 1), v[15:8]);
    endtask

    task automatic read16(input int ch, output logic [15:0] v);
        logic [7:0] h, l;
        rd(3'(2 * ch + 1), h);
        rd(3'(2 * ch), l);
        v = {h, l};
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_cnt = 1'b1;
        repeat (4) @(negedge clk);
        ext_cnt = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_irq0(output longint t);
        int k = 0;
        @(negedge clk);
        while (!irq[0] && k < 4000) begin @(negedge clk); k++; end
        t = cyc;
    endtask

    task automatic period_test(input logic [2:0] code, input logic [15:0] n, input longint exp);
        longint t1, t2;
        wr(3'd4, {5'b0, code});
        load(0, n);
        wr(3'd5, 8'h03);
        wait_irq0(t1);
        wr(3'd5, 8'h03);
        wait_irq0(t2);
        check($sformatf("R2/R3 period code %0d", code), t2 - t1, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [15:0] v;
        rd(3'd5, d); check("R1 irq reg", d, 8'h00);
        rd(3'd4, d); check("R1 ctrl reg", d, 8'h00);
        read16(1, v); check("R1 count1", v, 16'h0000);
        check("R1 irq pins", irq, 2'b00);
    endtask

    task automatic t_periods();
        period_test(3'd0, 16'd9, 10);
        period_test(3'd1, 16'd5, 24);
        period_test(3'd3, 16'd2, 48);
        period_test(3'd6, 16'd3, 512);
        wr(3'd5, 8'h02);
    endtask

    task automatic t_ext_and_snapshot();
        logic [15:0] v;
        logic [7:0] h, l;
        wr(3'd4, 8'h07);
        load(0, 16'h12AB);
        ext_pulse();
        read16(0, v); check("R4 ext edge decrements", v, 16'h12AA);
        rd(3'd1, h);
        ext_pulse(); ext_pulse();
        rd(3'd0, l);
        check("R5 low from snapshot", {h, l}, 16'h12AA);
        read16(0, v); check("R5 new snapshot", v, 16'h12A8);
    endtask

    task automatic t_byte_load();
        logic [15:0] v;
        load(0, 16'h0100);
        wr(3'd0, 8'h55);
        read16(0, v); check("R6 lone low write no effect", v, 16'h0100);
        wr(3'd1, 8'h00);
        read16(0, v); check("R6 high write commits", v, 16'h0055);
        load(0, 16'h1234);
        load(0, 16'h0000);
        read16(0, v); check("R7 zero load", v, 16'h0000);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        load(0, 16'h0001);
        wr(3'd5, 8'h02);
        ext_pulse(); ext_pulse();
        check("R8 no flag when disabled", irq[0], 1'b0);
        load(0, 16'h0001);
        wr(3'd5, 8'h01);
        ext_pulse();
        check("R8 no flag before underflow", irq[0], 1'b0);
        ext_pulse();
        check("R3/R8 flag on underflow", irq[0], 1'b1);
        rd(3'd5, d); check("R8 status read", d, 8'h11);
        wr(3'd5, 8'h02);
        rd(3'd5, d); check("R8 disable and clear", d, 8'h00);
    endtask

    task automatic t_cascade();
        logic [15:0] v;
        load(0, 16'h0000);
        wr(3'd4, 8'hBF);
        load(1, 16'h0002);
        wr(3'd5, 8'h04);
        ext_pulse();
        read16(1, v); check("R4 cascade decrement", v, 16'h0001);
        ext_pulse(); ext_pulse();
        check("R4 cascade underflow flag", irq[1], 1'b1);
        read16(1, v); check("R9 auto-reload on", v, 16'h0002);
        wr(3'd5, 8'h0C);
        wr(3'd4, 8'h3F);
        load(1, 16'h0001);
        ext_pulse(); ext_pulse();
        check("R9 flag once", irq[1], 1'b1);
        wr(3'd5, 8'h0C);
        ext_pulse(); ext_pulse();
        check("R9 no second flag", irq[1], 1'b0);
        read16(1, v); check("R9 parked at zero", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periods();
        t_ext_and_snapshot();
        t_byte_load();
        t_irq();
        t_cascade();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule